// File: doc/BRIEF.md
# Partition Snoop Filter

Each board of a partitioned multiprocessor sees every snooped transaction that crosses the machine. This block sits on the board and decides, per transaction, whether the board takes it or drops it. It uses two inputs: the number of the board that issued the transaction and its physical address. A source that belongs to the same partition is always taken. A source that belongs only to the wider sharing group is taken when the address falls inside a window of this board's memory. That window is set in 64 KB pages.

Four configuration registers hold the partition membership mask, the sharing-group mask, and the lowest and highest window pages. Software loads them through a plain write port. Lookups arrive on a valid/ready stream, and one registered verdict leaves on a second valid/ready stream. The upstream side may present a lookup only while `lk_ready` is high. A lookup is consumed on a clock edge where `lk_valid` and `lk_ready` are both high. A verdict is held until the consumer raises `rs_ready`, and the input stalls while a verdict waits. A freshly reset board trusts only itself, so a board being brought in stays isolated until software widens its masks.

Top module: `part_filter`

## Requirements
- R1: After reset, both masks hold only this board's own bit (`SELF_ID`), the window is closed, and `rs_valid` is low. Only lookups from `SELF_ID` are accepted.
- R2: A lookup whose source bit is set in the partition mask is accepted with `rs_via` = 1, whatever its address.
- R3: A lookup whose source bit is clear in the partition mask is accepted with `rs_via` = 2 when two conditions hold: its bit is set in the group mask, and its page (address bits above bit 15) lies in the window.
- R4: Any other lookup is refused: `rs_accept` = 0 and `rs_via` = 0. This covers a page below the window low page, a page above the window high page, and a source absent from both masks.
- R5: Both window bounds are inclusive. Address bits 15..0 have no effect on the verdict.
- R6: A verdict appears on `rs_valid` in the cycle after its lookup handshake, with `rs_src` echoing the source.
- R7: While `rs_valid` is high and `rs_ready` is low, the verdict stays stable and `lk_ready` is low. `lk_ready` is high whenever no verdict is waiting or the consumer takes one in that cycle.
- R8: A write that lands on the same clock edge as a lookup handshake does not affect that lookup. It applies from the next lookup onward.
- R9: `cfg_sel` selects the target register: 0 is the partition mask, 1 is the group mask, 2 is the window low page and 3 is the window high page. Masks take the low 16 bits of `cfg_wdata`, bit n standing for board n.
- R10: When the low page exceeds the high page, the window is empty and no group-only source is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 24 | Write data |
| lk_valid | input | 1 | Lookup present |
| lk_ready | output | 1 | Lookup can be taken |
| lk_src | input | 4 | Issuing board number |
| lk_addr | input | 40 | Physical address |
| rs_valid | output | 1 | Verdict present |
| rs_ready | input | 1 | Consumer takes verdict |
| rs_accept | output | 1 | Board takes the transaction |
| rs_via | output | 2 | 0 refused, 1 partition, 2 window |
| rs_src | output | 4 | Source of the verdict's lookup |

## Verification
A configuration write and a lookup handshake can land on the same edge. The same edge can also carry a verdict being consumed while a new lookup is taken. The bench forces the first case on purpose. It shrinks the window in the same cycle as a lookup that hits it, and expects acceptance for that lookup and refusal for the identical lookup that follows. The reference model captures each verdict from its register copy before it applies that cycle's write. Long random phases with random back-pressure and random writes exercise both cases, and every output is compared against the model on each clock.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    RS_DOMAIN = 2'd0,
    RS_GROUP  = 2'd1,
    RS_BASE   = 2'd2,
    RS_LIMIT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    WHY_NONE   = 2'd0,
    WHY_DOMAIN = 2'd1,
    WHY_WINDOW = 2'd2
  } why_e;
endpackage

// File: rtl/pf_field.sv
// One configuration field with its own reset value and select code.
module pf_field #(
  parameter int          W        = 16,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [1:0]  SEL_CODE = 2'd0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      q <= RST_VAL;
    else if (we && sel == SEL_CODE)  q <= wdata;
  end
endmodule

// File: rtl/pf_regs.sv
// Configuration register set: two board masks and the window bounds.
module pf_regs #(
  parameter int NB      = 16,
  parameter int PAGE_W  = 24,
  parameter int DATA_W  = 24,
  parameter int SELF_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [NB-1:0]     dom_mask,
  output logic [NB-1:0]     grp_mask,
  output logic [PAGE_W-1:0] lo_page,
  output logic [PAGE_W-1:0] hi_page
);
  import pf_pkg::*;

  localparam logic [NB-1:0]     SELF_BIT = {{(NB-1){1'b0}}, 1'b1} << SELF_ID;
  localparam logic [PAGE_W-1:0] LO_RST   = '1;
  localparam logic [PAGE_W-1:0] HI_RST   = '0;

  logic [NB-1:0] masks [2];

  for (genvar k = 0; k < 2; k++) begin : g_mask
    localparam logic [1:0] CODE = (k == 0) ? RS_DOMAIN : RS_GROUP;
    pf_field #(.W(NB), .RST_VAL(SELF_BIT), .SEL_CODE(CODE)) i_mask (
      .clk(clk), .rst_n(rst_n), .we(we), .sel(sel),
      .wdata(wdata[NB-1:0]), .q(masks[k])
    );
  end

  assign dom_mask = masks[0];
  assign grp_mask = masks[1];

  pf_field #(.W(PAGE_W), .RST_VAL(LO_RST), .SEL_CODE(RS_BASE)) i_lo (
    .clk(clk), .rst_n(rst_n), .we(we), .sel(sel),
    .wdata(wdata[PAGE_W-1:0]), .q(lo_page)
  );

  pf_field #(.W(PAGE_W), .RST_VAL(HI_RST), .SEL_CODE(RS_LIMIT)) i_hi (
    .clk(clk), .rst_n(rst_n), .we(we), .sel(sel),
    .wdata(wdata[PAGE_W-1:0]), .q(hi_page)
  );
endmodule

// File: rtl/pf_decide.sv
// Combinational verdict from the source board and the address page.
module pf_decide #(
  parameter int NB     = 16,
  parameter int SRC_W  = 4,
  parameter int PAGE_W = 24
) (
  input  logic [SRC_W-1:0]  src,
  input  logic [PAGE_W-1:0] page,
  input  logic [NB-1:0]     dom_mask,
  input  logic [NB-1:0]     grp_mask,
  input  logic [PAGE_W-1:0] lo_page,
  input  logic [PAGE_W-1:0] hi_page,
  output logic              hit,
  output pf_pkg::why_e      why
);
  import pf_pkg::*;

  logic src_ok, dom_hit, grp_bit, in_win;

  always_comb begin
    src_ok  = (int'(src) < NB);
    dom_hit = src_ok && dom_mask[src];
    grp_bit = src_ok && grp_mask[src];
    in_win  = (page >= lo_page) && (page <= hi_page);
    if (dom_hit) begin
      why = WHY_DOMAIN;
      hit = 1'b1;
    end else if (grp_bit && in_win) begin
      why = WHY_WINDOW;
      hit = 1'b1;
    end else begin
      why = WHY_NONE;
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/pf_stage.sv
// Single-entry registered verdict stage with valid/ready on both sides.
module pf_stage #(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_hit,
  input  pf_pkg::why_e     in_why,
  input  logic [SRC_W-1:0] in_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_hit,
  output pf_pkg::why_e     out_why,
  output logic [SRC_W-1:0] out_src
);
  import pf_pkg::*;

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_hit <= 1'b0;
      out_why <= WHY_NONE;
      out_src <= '0;
    end else if (take) begin
      out_hit <= in_hit;
      out_why <= in_why;
      out_src <= in_src;
    end
  end
endmodule

// File: rtl/part_filter.sv
// Per-board partition snoop filter: top level.
module part_filter #(
  parameter int NB      = 16,
  parameter int ADDR_W  = 40,
  parameter int PG_SH   = 16,
  parameter int SELF_ID = 2,
  localparam int SRC_W  = $clog2(NB),
  localparam int PAGE_W = ADDR_W - PG_SH,
  localparam int DATA_W = (PAGE_W > NB) ? PAGE_W : NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [SRC_W-1:0]  lk_src,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_accept,
  output logic [1:0]        rs_via,
  output logic [SRC_W-1:0]  rs_src
);
  import pf_pkg::*;

  logic [NB-1:0]     dom_mask, grp_mask;
  logic [PAGE_W-1:0] lo_page, hi_page;
  logic              d_hit;
  why_e              d_why, s_why;

  pf_regs #(.NB(NB), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .SELF_ID(SELF_ID)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .dom_mask(dom_mask), .grp_mask(grp_mask), .lo_page(lo_page), .hi_page(hi_page)
  );

  pf_decide #(.NB(NB), .SRC_W(SRC_W), .PAGE_W(PAGE_W)) i_decide (
    .src(lk_src), .page(lk_addr[ADDR_W-1:PG_SH]),
    .dom_mask(dom_mask), .grp_mask(grp_mask),
    .lo_page(lo_page), .hi_page(hi_page),
    .hit(d_hit), .why(d_why)
  );

  pf_stage #(.SRC_W(SRC_W)) i_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(lk_valid), .in_ready(lk_ready),
    .in_hit(d_hit), .in_why(d_why), .in_src(lk_src),
    .out_valid(rs_valid), .out_ready(rs_ready),
    .out_hit(rs_accept), .out_why(s_why), .out_src(rs_src)
  );

  assign rs_via = s_why;
endmodule

// File: rtl/pf_filter_chk.sv
// Temporal checks on the filter ports, attached by bind.
module pf_filter_chk #(
  parameter int SRC_W   = 4,
  parameter int SELF_ID = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic             rs_accept,
  input logic [1:0]       rs_via,
  input logic [SRC_W-1:0] rs_src
);
  logic cfg_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_seen <= 1'b0;
    else if (cfg_we) cfg_seen <= 1'b1;
  end

  p_self_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !cfg_seen) |-> (rs_accept == (int'(rs_src) == SELF_ID)));

  p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ((rs_accept == (rs_via != 2'd0)) && (rs_via != 2'd3)));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);

  p_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs_valid) |-> $past(lk_valid && lk_ready));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=>
      (rs_valid && $stable(rs_via) && $stable(rs_src) && $stable(rs_accept)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !lk_ready);
endmodule

bind part_filter pf_filter_chk #(.SRC_W(SRC_W), .SELF_ID(SELF_ID)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready),
  .rs_accept(rs_accept), .rs_via(rs_via), .rs_src(rs_src)
);

// File: tb/test_part_filter.sv
module test_part_filter;
  localparam int P    = 10;
  localparam int NB   = 16;
  localparam int AW   = 40;
  localparam int SW   = 4;
  localparam int PW   = 24;
  localparam int DW   = 24;
  localparam int SELF = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [SW-1:0] lk_src = '0;
  logic [AW-1:0] lk_addr = '0;
  logic          rs_valid;
  logic          rs_ready = 1'b1;
  logic          rs_accept;
  logic [1:0]    rs_via;
  logic [SW-1:0] rs_src;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  logic [NB-1:0] m_dom, m_grp;
  logic [PW-1:0] m_lo, m_hi;
  logic [SW+1:0] expq [$];   // {via, src}

  part_filter #(.NB(NB), .ADDR_W(AW), .PG_SH(16), .SELF_ID(SELF)) i_part_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_src(lk_src), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_accept(rs_accept),
    .rs_via(rs_via), .rs_src(rs_src)
  );

  always #(P/2) clk = ~clk;

  function automatic logic [1:0] ref_via(input logic [SW-1:0] s, input logic [AW-1:0] a);
    logic [PW-1:0] pg;
    pg = a[AW-1:16];
    if (m_dom[s]) return 2'd1;
    if (m_grp[s] && pg >= m_lo && pg <= m_hi) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int page, input int low);
    logic [AW-1:0] a;
    a = '0;
    a[AW-1:16] = PW'(page);
    a[15:0] = 16'(low);
    return a;
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // One clock: drive inputs, compare outputs, advance the model.
  task automatic step(input bit we, input logic [1:0] sel, input int wd,
                      input bit lv, input int src, input logic [AW-1:0] a,
                      input bit rr, input string req);
    bit ev;
    cfg_we = we; cfg_sel = sel; cfg_wdata = DW'(wd);
    lk_valid = lv; lk_src = SW'(src); lk_addr = a; rs_ready = rr;
    #(P/4);
    vectors++;
    ev = (expq.size() > 0);
    if (rs_valid !== ev) fail(req, "rs_valid", int'(rs_valid), int'(ev));
    else if (ev) begin
      if (rs_via !== expq[0][SW+1:SW]) fail(req, "rs_via", int'(rs_via), int'(expq[0][SW+1:SW]));
      if (rs_accept !== (expq[0][SW+1:SW] != 2'd0))
        fail(req, "rs_accept", int'(rs_accept), int'(expq[0][SW+1:SW] != 2'd0));
      if (rs_src !== expq[0][SW-1:0]) fail(req, "rs_src", int'(rs_src), int'(expq[0][SW-1:0]));
    end
    if (lk_ready !== (!ev || rr)) fail("R7", "lk_ready", int'(lk_ready), int'(!ev || rr));
    // model for the coming edge: pop, push from pre-write registers, then write
    if (ev && rr) void'(expq.pop_front());
    if (lv && (!ev || rr)) expq.push_back({ref_via(SW'(src), a), SW'(src)});
    if (we) begin
      case (sel)
        2'd0: m_dom = NB'(wd);
        2'd1: m_grp = NB'(wd);
        2'd2: m_lo  = PW'(wd);
        default: m_hi = PW'(wd);
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input int src, input int page, input int low, input string req);
    step(1'b0, 2'd0, 0, 1'b1, src, mk_addr(page, low), 1'b1, req);
  endtask

  task automatic wr(input logic [1:0] sel, input int wd, input string req);
    step(1'b1, sel, wd, 1'b0, 0, '0, 1'b1, req);
  endtask

  initial begin
    m_dom = NB'(1) << SELF; m_grp = NB'(1) << SELF; m_lo = '1; m_hi = '0;
    repeat (3) @(negedge clk);
    vectors++;
    if (rs_valid !== 1'b0) fail("R1", "rs_valid in reset", int'(rs_valid), 0);
    rst_n = 1'b1;

    // R1: freshly reset board accepts itself only
    look(SELF, 5, 0, "R1");
    look(3, 5, 0, "R1");
    look(0, 0, 0, "R1");
    // R10: group member but window still empty after reset
    wr(2'd1, (1 << 3) | (1 << SELF), "R9");
    look(3, 0, 0, "R10");
    look(3, 24'hFFFFFF, 16'hFFFF, "R10");
    // R9 / R2: widen partition
    wr(2'd0, (1 << 0) | (1 << 5) | (1 << SELF), "R9");
    look(5, 24'h123456, 16'h0, "R2");
    look(0, 0, 16'hABCD, "R2");
    // R3 / R4 / R5: window [0x100, 0x1FF] for group member 7
    wr(2'd1, 1 << 7, "R9");
    wr(2'd2, 24'h100, "R9");
    wr(2'd3, 24'h1FF, "R9");
    look(7, 24'h100, 0, "R5");
    look(7, 24'h1FF, 16'hFFFF, "R5");
    look(7, 24'h150, 16'h1234, "R3");
    look(7, 24'h0FF, 16'hFFFF, "R4");
    look(7, 24'h200, 16'h0000, "R4");
    look(9, 24'h150, 0, "R4");
    look(5, 24'h900, 0, "R2");
    // R8: shrink the window on the same edge as a hitting lookup
    step(1'b1, 2'd3, 24'h0, 1'b1, 7, mk_addr(24'h150, 0), 1'b1, "R8");
    look(7, 24'h150, 0, "R8");
    // R10: low above high
    wr(2'd3, 24'h180, "R9");
    wr(2'd2, 24'h181, "R9");
    look(7, 24'h180, 0, "R10");
    look(7, 24'h181, 0, "R10");
    // R7: back-pressure with a lookup pending
    step(1'b0, 2'd0, 0, 1'b1, 5, mk_addr(1, 0), 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 0, 1'b1, 0, mk_addr(2, 0), 1'b0, "R7");
    step(1'b0, 2'd0, 0, 1'b1, 0, mk_addr(2, 0), 1'b1, "R6");
    step(1'b0, 2'd0, 0, 1'b0, 0, '0, 1'b1, "R6");
    // random phase, small page range so windows hit
    for (int i = 0; i < 3000; i++) begin
      bit we;
      logic [1:0] sel;
      int wd;
      we  = ($urandom_range(0, 7) == 0);
      sel = 2'($urandom_range(0, 3));
      wd  = (sel < 2) ? int'($urandom_range(0, 16'hFFFF)) : int'($urandom_range(0, 15));
      step(we, sel, wd, 1'($urandom_range(0, 1)), int'($urandom_range(0, NB - 1)),
           mk_addr(int'($urandom_range(0, 15)), int'($urandom_range(0, 16'hFFFF))),
           ($urandom_range(0, 3) != 0), "R3");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule